// File: doc/BRIEF.md
# Single-Precision to 8-Bit Float Saturating Converter

This block takes an IEEE single-precision value and turns it into one of two 8-bit floating-point encodings. A one-bit select picks the target. The first target has a sign, a 4-bit exponent and a 3-bit fraction. The second has a sign, a 5-bit exponent and a 2-bit fraction. Neither target can produce an infinity: any result too large to represent settles on the largest finite magnitude of the chosen format. The 4/3 format also has no NaN code.

Each conversion is requested with a single valid strobe, and the result appears one clock later with its own valid strobe. There is no backpressure. Four rounding directions can be selected per request. An optional flush-to-zero control acts on the already-rounded result, so a value that rounds up into the normal range is kept.

Top module: `fp8_sat_cvt`

## Requirements
- R1: With `fmtSel`=0 the output is {sign, 4-bit exponent with bias 7, 3-bit fraction}. With `fmtSel`=1 it is {sign, 5-bit exponent with bias 15, 2-bit fraction}. Values that are exactly representable convert without error.
- R2: `rndMode` selects the rounding direction: 0 = nearest with ties to even code, 1 = toward zero, 2 = toward +infinity, 3 = toward -infinity.
- R3: A finite input whose rounded magnitude exceeds the largest finite value gives that value with the input's sign, in every rounding mode. The largest finite code is 0x7E (448) in the 4/3 format and 0x7B (57344) in the 5/2 format.
- R4: An input of +infinity or -infinity gives the largest finite value with the matching sign (0x7E/0xFE or 0x7B/0xFB).
- R5: In the 5/2 format a NaN input gives 0x7F with the input's sign bit on top (0x7F or 0xFF).
- R6: In the 4/3 format any NaN input gives 0x7E, whatever the input sign; the code 0x7F is never output in that format.
- R7: With flush-to-zero off, results below the smallest normal are correctly rounded subnormal codes (exponent field 0). Zero and single-precision subnormal inputs are rounded like any other tiny value, and the sign of a zero result follows the input.
- R8: With `ftzEn`=1, rounding is applied first. A rounded result with exponent field 0 and a nonzero fraction then becomes a zero of the input's sign. A value that rounds up to the smallest normal is kept.
- R9: `outValid` is `inValid` delayed by one clock. `outData` takes a new result only on cycles after `inValid` was high, and otherwise holds.
- R10: While `rstN` is low at a clock edge, `outValid` and `outData` are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| inValid | input | 1 | Conversion request strobe |
| inData | input | 32 | Single-precision source bits |
| fmtSel | input | 1 | 0 = 4/3 target, 1 = 5/2 target |
| rndMode | input | 2 | Rounding direction select |
| ftzEn | input | 1 | Flush subnormal results to zero |
| outValid | output | 1 | Result strobe, one clock after the request |
| outData | output | 8 | Converted 8-bit code |

## Verification
The top module has no parameters of its own; both target formats are fixed constants in the package. The bench builds the block with its defaults, so both per-format rounding paths are present and reachable through `fmtSel`. That makes every format pairing reachable from one build: mode against format, flush against format, NaN against format. It also reaches both saturation limits, including the 4/3 case where the rounded code would otherwise land on the forbidden 0x7F. A seeded sweep then compares random inputs, with exponents spanning deep underflow to overflow, against a model in the bench that searches the code space using real arithmetic.

// File: rtl/fp8_sat_cvt_pkg.sv
package fp8_sat_cvt_pkg;

  localparam int SRC_W     = 32;
  localparam int SRC_EXP_W = 8;
  localparam int SRC_MAN_W = 23;
  localparam int SRC_BIAS  = 127;
  localparam int DST_W     = 8;
  localparam int MAG_W     = DST_W - 1;
  localparam int FMT_COUNT = 2;

  typedef enum logic [1:0] {
    RND_NEAR_EVEN = 2'd0,
    RND_TO_ZERO   = 2'd1,
    RND_UP        = 2'd2,
    RND_DOWN      = 2'd3
  } rndMode_e;

  // strobes passed from control to datapath
  typedef struct packed {
    logic wideExp;   // selects the 5/2 target
    logic incNear;   // nearest-even increment rule
    logic incAway;   // increment magnitude on any discarded bit
    logic flush;     // flush subnormal results after rounding
    logic load;      // capture a new result
  } cvtStrobe_t;

  // format index 0: 4/3 target, index 1: 5/2 target
  function automatic int fmtManW(int f);
    return (f == 0) ? 3 : 2;
  endfunction

  function automatic int fmtBias(int f);
    return (f == 0) ? 7 : 15;
  endfunction

  function automatic int fmtMaxMag(int f);
    return (f == 0) ? 126 : 123;
  endfunction

endpackage

// File: rtl/fp8_sat_cvt_ctrl.sv
module fp8_sat_cvt_ctrl
  import fp8_sat_cvt_pkg::*;
(
  input  logic       inValid,
  input  logic       fmtSel,
  input  logic [1:0] rndMode,
  input  logic       ftzEn,
  input  logic       srcSign,
  output cvtStrobe_t strobe
);

  rndMode_e modeSel;

  always_comb begin
    modeSel        = rndMode_e'(rndMode);
    strobe.wideExp = fmtSel;
    strobe.incNear = (modeSel == RND_NEAR_EVEN);
    strobe.incAway = ((modeSel == RND_UP) && !srcSign) ||
                     ((modeSel == RND_DOWN) && srcSign);
    strobe.flush   = ftzEn;
    strobe.load    = inValid;
  end

endmodule

// File: rtl/fp8_sat_cvt_narrow.sv
module fp8_sat_cvt_narrow
  import fp8_sat_cvt_pkg::*;
#(
  parameter int MAN_W   = 3,
  parameter int BIAS    = 7,
  parameter int MAX_MAG = 126
) (
  input  logic [SRC_EXP_W-1:0] expRaw,
  input  logic [SRC_MAN_W-1:0] manRaw,
  input  logic                 incNear,
  input  logic                 incAway,
  input  logic                 flush,
  output logic [MAG_W-1:0]     magOut
);

  localparam int SIG_W    = SRC_MAN_W + 1;
  localparam int LOW_W    = 32;
  localparam int EXT_W    = SIG_W + LOW_W;
  localparam int EMIN     = 1 - BIAS;
  localparam int BASE_SH  = SRC_MAN_W - MAN_W;
  localparam int SH_CAP   = SIG_W + 2;
  localparam int SH_W     = $clog2(SH_CAP + 1);
  localparam logic [31:0] MIN_NORM = 32'(1) << MAN_W;

  logic [SIG_W-1:0] sig;
  logic [SH_W-1:0]  shAmt;
  logic [EXT_W-1:0] ext;
  logic [SIG_W-1:0] quant;
  logic             grd;
  logic             stk;
  logic             inc;
  logic [31:0]      code;
  int               unb;
  int               under;
  int               shTot;
  int               bexp;

  always_comb begin
    sig   = {(expRaw != '0), manRaw};
    unb   = (expRaw == '0) ? (1 - SRC_BIAS) : (int'(expRaw) - SRC_BIAS);
    under = EMIN - unb;
    shTot = (under > 0) ? (BASE_SH + under) : BASE_SH;
    shAmt = (shTot > SH_CAP) ? SH_W'(SH_CAP) : SH_W'(shTot);
    ext   = {sig, {LOW_W{1'b0}}} >> shAmt;
    quant = ext[EXT_W-1:LOW_W];
    grd   = ext[LOW_W-1];
    stk   = |ext[LOW_W-2:0];
    inc   = incNear ? (grd & (stk | quant[0])) : (incAway & (grd | stk));
    bexp  = (under > 0) ? 1 : (unb + BIAS);
    // exponent and fraction added together so a fraction carry bumps the exponent
    code  = (32'(bexp - 1) << MAN_W) + 32'(quant) + 32'(inc);
    if (code > 32'(MAX_MAG))
      magOut = MAG_W'(MAX_MAG);
    else if (flush && (code != '0) && (code < MIN_NORM))
      magOut = '0;
    else
      magOut = code[MAG_W-1:0];
  end

endmodule

// File: rtl/fp8_sat_cvt_dp.sv
module fp8_sat_cvt_dp
  import fp8_sat_cvt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  cvtStrobe_t       strobe,
  input  logic [SRC_W-1:0] srcBits,
  output logic [DST_W-1:0] resData,
  output logic             resValid
);

  logic                 srcSign;
  logic [SRC_EXP_W-1:0] expRaw;
  logic [SRC_MAN_W-1:0] manRaw;
  logic                 isNan;
  logic                 isInf;
  logic [MAG_W-1:0]     magF [FMT_COUNT];
  logic [MAG_W-1:0]     maxF [FMT_COUNT];
  logic [DST_W-1:0]     nxtData;

  assign srcSign = srcBits[SRC_W-1];
  assign expRaw  = srcBits[SRC_W-2:SRC_MAN_W];
  assign manRaw  = srcBits[SRC_MAN_W-1:0];
  assign isNan   = (&expRaw) && (manRaw != '0);
  assign isInf   = (&expRaw) && (manRaw == '0);

  generate
    for (genvar f = 0; f < FMT_COUNT; f++) begin : g_fmt
      assign maxF[f] = MAG_W'(fmtMaxMag(f));
      fp8_sat_cvt_narrow #(
        .MAN_W  (fmtManW(f)),
        .BIAS   (fmtBias(f)),
        .MAX_MAG(fmtMaxMag(f))
      ) u_narrow (
        .expRaw (expRaw),
        .manRaw (manRaw),
        .incNear(strobe.incNear),
        .incAway(strobe.incAway),
        .flush  (strobe.flush),
        .magOut (magF[f])
      );
    end
  endgenerate

  always_comb begin
    if (isNan)
      nxtData = strobe.wideExp ? {srcSign, {MAG_W{1'b1}}} : {1'b0, maxF[0]};
    else if (isInf)
      nxtData = {srcSign, maxF[strobe.wideExp]};
    else
      nxtData = {srcSign, magF[strobe.wideExp]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resData  <= '0;
      resValid <= 1'b0;
    end else begin
      resValid <= strobe.load;
      if (strobe.load) resData <= nxtData;
    end
  end

endmodule

// File: rtl/fp8_sat_cvt.sv
module fp8_sat_cvt
  import fp8_sat_cvt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [31:0] inData,
  input  logic        fmtSel,
  input  logic [1:0]  rndMode,
  input  logic        ftzEn,
  output logic        outValid,
  output logic [7:0]  outData
);

  cvtStrobe_t strobe;

  fp8_sat_cvt_ctrl u_ctrl (
    .inValid(inValid),
    .fmtSel (fmtSel),
    .rndMode(rndMode),
    .ftzEn  (ftzEn),
    .srcSign(inData[SRC_W-1]),
    .strobe (strobe)
  );

  fp8_sat_cvt_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .srcBits (inData),
    .resData (outData),
    .resValid(outValid)
  );

endmodule

// File: rtl/fp8_sat_cvt_chk.sv
module fp8_sat_cvt_chk (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [31:0] inData,
  input logic        fmtSel,
  input logic        ftzEn,
  input logic        outValid,
  input logic [7:0]  outData
);

  logic srcNan;
  logic srcInf;
  assign srcNan = (inData[30:23] == 8'hFF) && (inData[22:0] != 23'd0);
  assign srcInf = (inData[30:23] == 8'hFF) && (inData[22:0] == 23'd0);

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R9
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  // R9
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(outData));

  // R6
  narrow_no_nan_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !fmtSel) |=> (outData[6:0] != 7'h7F));

  // R5
  wide_nan_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && fmtSel && srcNan) |=> (outData == {$past(inData[31]), 7'h7F}));

  // R6
  narrow_nan_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !fmtSel && srcNan) |=> (outData == 8'h7E));

  // R4
  wide_inf_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && fmtSel && srcInf) |=> (outData == {$past(inData[31]), 7'h7B}));

  // R8
  narrow_ftz_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !fmtSel && ftzEn) |=> ((outData[6:3] != 4'd0) || (outData[2:0] == 3'd0)));

  // R8
  wide_ftz_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && fmtSel && ftzEn) |=> ((outData[6:2] != 5'd0) || (outData[1:0] == 2'd0)));

endmodule

bind fp8_sat_cvt fp8_sat_cvt_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .inData  (inData),
  .fmtSel  (fmtSel),
  .ftzEn   (ftzEn),
  .outValid(outValid),
  .outData (outData)
);

// File: tb/fp8_sat_cvt_bench.sv
`timescale 1ns/1ps
module fp8_sat_cvt_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inData = '0;
  logic        fmtSel = 1'b0;
  logic [1:0]  rndMode = 2'd0;
  logic        ftzEn = 1'b0;
  logic        outValid;
  logic [7:0]  outData;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  fp8_sat_cvt u_fp8_sat_cvt (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .fmtSel(fmtSel), .rndMode(rndMode), .ftzEn(ftzEn),
    .outValid(outValid), .outData(outData)
  );

  function automatic real pow2(int e);
    real r = 1.0;
    if (e >= 0) for (int i = 0; i < e; i++) r = r * 2.0;
    else for (int i = 0; i < -e; i++) r = r / 2.0;
    return r;
  endfunction

  function automatic real decodeMag(int code, bit wide);
    int m = wide ? 2 : 3;
    int b = wide ? 15 : 7;
    int ef = code >> m;
    int mf = code & ((1 << m) - 1);
    if (ef == 0) return real'(mf) * pow2(1 - b - m);
    return real'((1 << m) + mf) * pow2(ef - b - m);
  endfunction

  // independent reference: search the code space with real arithmetic
  function automatic logic [7:0] refModel(logic [31:0] x, bit wide, logic [1:0] mode, bit ftz);
    bit s = x[31];
    int e = int'(x[30:23]);
    int mn = int'(x[22:0]);
    int maxc = wide ? 123 : 126;
    int m = wide ? 2 : 3;
    int lo = 0;
    int hi;
    int pick;
    real a;
    real dlo;
    real dhi;
    if (e == 255 && mn != 0) return wide ? {s, 7'h7F} : 8'h7E;
    if (e == 255) return {s, 7'(maxc)};
    if (e == 0) a = real'(mn) * pow2(-149);
    else a = real'(8388608 + mn) * pow2(e - 150);
    for (int c = 0; c <= maxc; c++) if (decodeMag(c, wide) <= a) lo = c;
    hi = (decodeMag(lo, wide) < a && lo < maxc) ? lo + 1 : lo;
    case (mode)
      2'd0: begin
        dlo = a - decodeMag(lo, wide);
        dhi = decodeMag(hi, wide) - a;
        if (hi == lo || dlo < dhi) pick = lo;
        else if (dhi < dlo) pick = hi;
        else pick = ((lo & 1) == 0) ? lo : hi;
      end
      2'd1: pick = lo;
      2'd2: pick = s ? lo : hi;
      default: pick = s ? hi : lo;
    endcase
    if (ftz && pick > 0 && pick < (1 << m)) pick = 0;
    return {s, 7'(pick)};
  endfunction

  task automatic check(string req, logic [31:0] x, bit wide, logic [1:0] mode, bit ftz,
                       logic [7:0] got, logic [7:0] expv);
    checks++;
    if (got !== expv) begin
      errors++;
      $display("FAIL %s in=%h fmt=%0d mode=%0d ftz=%0d actual=%h expected=%h",
               req, x, wide, mode, ftz, got, expv);
    end
  endtask

  task automatic convert(string req, logic [31:0] x, bit wide, logic [1:0] mode, bit ftz,
                         logic [7:0] expv);
    @(negedge clk);
    inValid = 1'b1; inData = x; fmtSel = wide; rndMode = mode; ftzEn = ftz;
    @(negedge clk);
    inValid = 1'b0;
    checks++;
    if (outValid !== 1'b1) begin
      errors++;
      $display("FAIL R9 outValid actual=%b expected=1", outValid);
    end
    check(req, x, wide, mode, ftz, outData, expv);
  endtask

  task automatic testReset();
    checks++;
    if (outValid !== 1'b0 || outData !== 8'h00) begin
      errors++;
      $display("FAIL R10 reset actual=%b/%h expected=0/00", outValid, outData);
    end
  endtask

  task automatic testExact();
    convert("R1 one narrow", 32'h3F800000, 1'b0, 2'd0, 1'b0, 8'h38);
    convert("R1 one wide", 32'h3F800000, 1'b1, 2'd0, 1'b0, 8'h3C);
    convert("R1 -2.5 narrow", 32'hC0200000, 1'b0, 2'd0, 1'b0, 8'hC2);
    convert("R1 -2.5 wide", 32'hC0200000, 1'b1, 2'd0, 1'b0, 8'hC1);
  endtask

  task automatic testRounding();
    convert("R2 tie to even low", 32'h3F880000, 1'b0, 2'd0, 1'b0, 8'h38);
    convert("R2 tie to even high", 32'h3F980000, 1'b0, 2'd0, 1'b0, 8'h3A);
    convert("R2 toward zero", 32'h3F980000, 1'b0, 2'd1, 1'b0, 8'h39);
    convert("R2 toward +inf pos", 32'h3F880000, 1'b0, 2'd2, 1'b0, 8'h39);
    convert("R2 toward +inf neg", 32'hBF880000, 1'b0, 2'd2, 1'b0, 8'hB8);
    convert("R2 toward -inf neg", 32'hBF880000, 1'b0, 2'd3, 1'b0, 8'hB9);
  endtask

  task automatic testSaturate();
    convert("R3 big narrow", 32'h49742400, 1'b0, 2'd0, 1'b0, 8'h7E);
    convert("R3 big wide", 32'h49742400, 1'b1, 2'd0, 1'b0, 8'h7B);
    convert("R3 -big narrow up", 32'hC9742400, 1'b0, 2'd3, 1'b0, 8'hFE);
    convert("R3 -big wide down", 32'hC9742400, 1'b1, 2'd3, 1'b0, 8'hFB);
    convert("R3 464 narrow", 32'h43E80000, 1'b0, 2'd0, 1'b0, 8'h7E);
    convert("R3 480 narrow up", 32'h43F00000, 1'b0, 2'd2, 1'b0, 8'h7E);
  endtask

  task automatic testSpecials();
    convert("R4 +inf narrow", 32'h7F800000, 1'b0, 2'd0, 1'b0, 8'h7E);
    convert("R4 -inf narrow", 32'hFF800000, 1'b0, 2'd2, 1'b0, 8'hFE);
    convert("R4 +inf wide", 32'h7F800000, 1'b1, 2'd1, 1'b0, 8'h7B);
    convert("R4 -inf wide", 32'hFF800000, 1'b1, 2'd0, 1'b0, 8'hFB);
    convert("R5 +nan wide", 32'h7FC00000, 1'b1, 2'd0, 1'b0, 8'h7F);
    convert("R5 -nan wide", 32'hFFC00000, 1'b1, 2'd0, 1'b0, 8'hFF);
    convert("R6 +nan narrow", 32'h7F800001, 1'b0, 2'd0, 1'b0, 8'h7E);
    convert("R6 -nan narrow", 32'hFFC00000, 1'b0, 2'd3, 1'b0, 8'h7E);
  endtask

  task automatic testSubnormal();
    convert("R7 min sub narrow", 32'h3B000000, 1'b0, 2'd0, 1'b0, 8'h01);
    convert("R7 3 sub narrow", 32'h3BC00000, 1'b0, 2'd0, 1'b0, 8'h03);
    convert("R7 min sub wide", 32'h37800000, 1'b1, 2'd0, 1'b0, 8'h01);
    convert("R7 half sub tie", 32'h3A800000, 1'b0, 2'd0, 1'b0, 8'h00);
    convert("R7 half sub up", 32'h3A800000, 1'b0, 2'd2, 1'b0, 8'h01);
    convert("R7 src subnormal up", 32'h00000001, 1'b0, 2'd2, 1'b0, 8'h01);
    convert("R7 src subnormal near", 32'h00000001, 1'b1, 2'd0, 1'b0, 8'h00);
    convert("R7 neg zero", 32'h80000000, 1'b1, 2'd0, 1'b0, 8'h80);
  endtask

  task automatic testFlush();
    convert("R8 flush min sub", 32'h3B000000, 1'b0, 2'd0, 1'b1, 8'h00);
    convert("R8 flush neg sub", 32'hBB000000, 1'b0, 2'd0, 1'b1, 8'h80);
    convert("R8 round then keep", 32'h3C700000, 1'b0, 2'd0, 1'b1, 8'h08);
    convert("R8 truncate then flush", 32'h3C700000, 1'b0, 2'd1, 1'b1, 8'h00);
    convert("R8 flush wide", 32'h37800000, 1'b1, 2'd0, 1'b1, 8'h00);
  endtask

  task automatic testHold();
    convert("R9 load", 32'h3F800000, 1'b0, 2'd0, 1'b0, 8'h38);
    @(negedge clk);
    inValid = 1'b0; inData = 32'h49742400; fmtSel = 1'b1;
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0) begin
      errors++;
      $display("FAIL R9 idle outValid actual=%b expected=0", outValid);
    end
    check("R9 hold", inData, 1'b1, 2'd0, 1'b0, outData, 8'h38);
  endtask

  task automatic testSweep();
    logic [31:0] rs = 32'h1234ABCD;
    for (int n = 0; n < 2000; n++) begin
      logic [31:0] x;
      logic [3:0] ctl;
      rs = rs ^ (rs << 13); rs = rs ^ (rs >> 17); rs = rs ^ (rs << 5);
      x = {rs[31], 8'(100 + int'(rs[30:25])), rs[22:0]};
      ctl = rs[27:24] ^ rs[3:0];
      convert("R2 sweep", x, ctl[0], ctl[2:1], ctl[3],
              refModel(x, ctl[0], ctl[2:1], ctl[3]));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testExact();
    testRounding();
    testSaturate();
    testSpecials();
    testSubnormal();
    testFlush();
    testHold();
    testSweep();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule